// File: doc/BRIEF.md
# Accuracy-Configurable Carry-Maskable Adder

This block is a 16-bit combinational adder built on two levels of carry look-ahead. Its accuracy is chosen at run time. The operands are split into four 4-bit groups. Each of the three lower groups has an enable bit. When a group's enable bit is low, every carry-generate term inside that group is forced to zero, so the group cannot start a carry of its own.

A carry that a lower, enabled group produces still travels through the propagate terms of a disabled group. With all enables high, the result is the exact sum. With enables low, the low part of the result moves towards a plain bitwise XOR of the operands. Error-tolerant datapaths use this to trade precision for shorter carry activity. The top group always generates carries normally. There is no carry-in, and the final group-boundary carry is the carry-out.

Top module: `cmask_adder`

## Requirements
- R1: When all three bits of `keep_gen` are 1, `{carry_out, sum}` equals the exact 17-bit value `op_a + op_b`.
- R2: Bits 15 to 12 are never masked: a carry produced within them reaches `carry_out` for every `keep_gen` value (for example 0xF000 + 0xF000 gives sum 0xE000 and carry_out 1 with `keep_gen` = 3'b000).
- R3: `keep_gen[k]` = 0 suppresses carry generation inside bits 4k+3..4k (k = 0, 1, 2). For example 0x000F + 0x000F with `keep_gen` = 3'b110 gives sum 0x0000.
- R4: A carry leaving a lower enabled group still propagates through a masked group's propagate terms. For example 0x00F1 + 0x000F with `keep_gen` = 3'b101 gives sum 0x0100.
- R5: Each sum bit i ≥ 1 is (op_a[i] XOR op_b[i]) XOR carry(i−1). Sum bit 0 is op_a[0] XOR op_b[0] (no carry-in). Carry(i) is masked-generate(i) OR (propagate(i) AND carry(i−1)).
- R6: With `keep_gen` = 3'b000, the low 12 result bits equal `op_a XOR op_b` in those bits.
- R7: When no bit position has both operand bits set, the result is `op_a XOR op_b` with carry_out 0, whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| keep_gen | input | 3 | Per-group generate enable for groups 0..2, active high |
| sum | output | 16 | Result bits |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
The assertions are immediate checks on a purely combinational path. They take for granted that the operands and enables are two-state, settled values. They also take for granted that each input vector is held long enough for the look-ahead network to resolve before it is judged. The bench changes inputs only on the rising clock edge and compares results on the falling edge. It drives only defined 0/1 values. Its reference model walks a bit-serial ripple chain with the same generate gating, so it never reuses the look-ahead grouping.

// File: rtl/cmask_adder.sv
module cmask_adder #(
  parameter int GRP = 4,
  parameter int NGRP = 4
) (
  input  logic [GRP*NGRP-1:0] op_a,
  input  logic [GRP*NGRP-1:0] op_b,
  input  logic [NGRP-2:0]     keep_gen,
  output logic [GRP*NGRP-1:0] sum,
  output logic                carry_out
);
  localparam int W = GRP * NGRP;

  logic [W-1:0]    prop, gen, gmask, cy;
  logic [NGRP-1:0] gp, gg, gin;

  assign prop = op_a ^ op_b;

  genvar k, j;
  generate
    for (k = 0; k < NGRP; k++) begin : g_mask
      if (k == NGRP - 1) begin : g_top
        assign gmask[k*GRP +: GRP] = '1;
      end else begin : g_low
        assign gmask[k*GRP +: GRP] = {GRP{keep_gen[k]}};
      end
    end
  endgenerate

  assign gen = op_a & op_b & gmask;

  generate
    for (k = 0; k < NGRP; k++) begin : g_unit
      logic [GRP-1:0] pl, gl, cl;
      assign pl = prop[k*GRP +: GRP];
      assign gl = gen[k*GRP +: GRP];
      assign gp[k] = &pl;
      always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < GRP; i++) acc = gl[i] | (pl[i] & acc);
        gg[k] = acc;
      end
      for (j = 0; j < GRP - 1; j++) begin : g_bit
        logic [j:0] terms;
        for (genvar t = 0; t <= j; t++) begin : g_term
          assign terms[t] = gl[t] & ((t == j) ? 1'b1 : (&pl[j:(t == j ? j : t+1)]));
        end
        assign cl[j] = (|terms) | ((&pl[j:0]) & gin[k]);
      end
      assign cl[GRP-1] = 1'b0;
      assign cy[k*GRP +: GRP-1] = cl[GRP-2:0];
    end
  endgenerate

  assign gin[0] = 1'b0;
  generate
    for (k = 0; k < NGRP; k++) begin : g_l2
      always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = 0; i <= k; i++) acc = gg[i] | (gp[i] & acc);
        cy[k*GRP + GRP - 1] = acc;
      end
      if (k > 0) begin : g_cin
        assign gin[k] = cy[k*GRP - 1];
      end
    end
  endgenerate

  assign sum       = prop ^ {cy[W-2:0], 1'b0};
  assign carry_out = cy[W-1];

  always_comb begin
    // R1
    exact_sum_chk: assert (!(&keep_gen) || ({carry_out, sum} == ({1'b0, op_a} + {1'b0, op_b})));
    // R6
    xor_low_chk: assert ((|keep_gen) || (sum[W-GRP-1:0] == prop[W-GRP-1:0]));
    // R7
    no_gen_chk: assert ((|(op_a & op_b)) || ((sum == prop) && !carry_out));
    // R2
    top_gen_chk: assert (!(op_a[W-1] & op_b[W-1]) || carry_out);
  end
endmodule

// File: tb/sim_cmask_adder.sv
module sim_cmask_adder;
  logic clk = 0, rst = 1;
  logic [15:0] a = 0, b = 0;
  logic [2:0]  m = 0;
  logic [15:0] sum;
  logic        co;
  int nvec = 0, nbad = 0;
  bit done = 0;

  typedef struct { logic [16:0] exp; string req; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  cmask_adder u0 (.op_a(a), .op_b(b), .keep_gen(m), .sum(sum), .carry_out(co));

  function automatic logic [16:0] model(logic [15:0] x, logic [15:0] y, logic [2:0] en);
    logic c = 0;
    logic [15:0] s;
    for (int i = 0; i < 16; i++) begin
      logic p, g;
      p = x[i] ^ y[i];
      g = x[i] & y[i] & ((i >= 12) ? 1'b1 : en[i/4]);
      s[i] = p ^ c;
      c = g | (p & c);
    end
    return {c, s};
  endfunction

  task automatic drive(logic [15:0] x, logic [15:0] y, logic [2:0] en, string req, logic [16:0] fixed = 17'h1FFFF);
    item_t it;
    @(posedge clk);
    a <= x; b <= y; m <= en;
    it.exp = (fixed !== 17'h1FFFF) ? fixed : model(x, y, en);
    it.req = req;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      nvec++;
      if ({co, sum} !== it.exp) begin
        nbad++;
        $display("FAIL %s: got %h expected %h", it.req, {co, sum}, it.exp);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 0;
    drive(16'h0000, 16'h0000, 3'b000, "R7 zero", 17'h00000);
    // R1 exact corner cases
    drive(16'hFFFF, 16'h0001, 3'b111, "R1 ones+1", 17'h10000);
    drive(16'hAAAA, 16'h5555, 3'b111, "R1 alt", 17'h0FFFF);
    drive(16'h1234, 16'h4321, 3'b111, "R1", 17'h05555);
    drive(16'hFFFF, 16'hFFFF, 3'b111, "R1 max", 17'h1FFFE);
    // R2
    drive(16'hF000, 16'hF000, 3'b000, "R2 top", 17'h1E000);
    // R3
    drive(16'h000F, 16'h000F, 3'b110, "R3 g0 masked", 17'h00000);
    drive(16'h0F00, 16'h0100, 3'b011, "R3 g2 masked", 17'h00E00);
    // R4
    drive(16'h00F1, 16'h000F, 3'b101, "R4 pass through", 17'h00100);
    drive(16'hFFFF, 16'h0001, 3'b001, "R4 ripple to cout", 17'h10000);
    // R5
    drive(16'h0001, 16'h0001, 3'b111, "R5 bit0", 17'h00002);
    drive(16'h0001, 16'h0000, 3'b000, "R5 bit0 xor", 17'h00001);
    // R6
    drive(16'h0FFF, 16'h0FFF, 3'b000, "R6 xor low", 17'h00000);
    drive(16'hA5A5, 16'h5A5A, 3'b000, "R6 alt", 17'h0FFFF);
    // R7
    drive(16'hF0F0, 16'h0F0F, 3'b010, "R7 disjoint", 17'h0FFFF);
    for (int e = 0; e < 8; e++) begin
      for (int n = 0; n < 300; n++) begin
        drive(16'($urandom), 16'($urandom), 3'(e), "R5 random");
      end
      drive(16'hFFFF, 16'h0001, 3'(e), "R4 ones+1");
      drive(16'h5555, 16'h5555, 3'(e), "R3 alt");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule